// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a 16-bit voltage-output converter. A host sends it 24-bit words over a three-wire link made of an active-low frame strobe, a serial clock and a data line. The three pins are brought into a fast system clock through two-flop synchronisers, and their edges are detected in that clock domain. Each word can do one of four things: set the converter code, move the output into one of three power-down loads, store a new power-on code, or trigger a software reset.

The block drives the live 16-bit code and a two-bit output-load select. It also drives a ready flag that stays low while the output stage recovers from power-down. The code is split into switch controls for the analog core. The top four bits become 15 thermometer segment lines, and the low twelve bits drive the binary ladder directly.

Top module: `dac_serial_front`

## Requirements
- R1: After reset the code output equals the reset value (0x0000, or 0x8000 when RESET_MID is 1), the load select is 00 and ready is 1.
- R2: A frame begins on a falling edge of the strobe. Bits are taken MSB first, one on each falling serial-clock edge, and the frame executes on the 24th such edge. Falling clock edges after the 24th are ignored while the strobe stays low.
- R3: If the strobe rises before the 24th falling edge, the frame is dropped and neither the code nor the load select changes. This holds even after 23 edges.
- R4: With the strobe high, serial-clock edges have no effect. Only a new falling edge of the strobe starts a frame.
- R5: Bits 21:20 of a frame set the load select: 00 normal, 01 high impedance, 10 100 kΩ to ground, 11 1 kΩ to ground.
- R6: A frame whose mode field is not 00 leaves the code unchanged, whatever its data field holds.
- R7: A frame with bit 22 set stores bits 15:0 as the reset code and leaves the live code unchanged. Bit 23 and bits 19:16 are ignored. A frame with bit 22 clear and mode 00 loads bits 15:0 into the code.
- R8: A frame whose bits 23:16 are all ones is a software reset. It loads the code from the reset code and sets the load select to 00. Once those eight bits are in, an early strobe rise executes the reset instead of dropping it.
- R9: Thermometer line i (0 to 14) is 1 exactly when i is less than code[15:12]. The 12 binary lines equal code[11:0].
- R10: Ready is 0 whenever the load select is not 00. On a change from a power-down mode to 00, ready stays 0 for exactly EXIT_CYCLES clock cycles, counted from the cycle in which the load select becomes 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sync_n_i | input | 1 | Frame strobe, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| sdi_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | 16 | Live converter code |
| load_sel_o | output | 2 | Output-load select (00 normal, 01 high-Z, 10 100 kΩ, 11 1 kΩ) |
| ready_o | output | 1 | Output stage ready (low during power-down and its exit time) |
| seg_therm_o | output | 15 | Thermometer segment switch lines |
| seg_bin_o | output | 12 | Binary ladder switch lines |

## Verification
The bench aborts frames after 10 and after 23 edges. A design that counts edges off by one would commit the 23-edge frame and corrupt the code. It sends power-down frames that carry non-zero data, which a careless design would load into the code. It also sends frames with bit 23 and bits 19:16 set, which a design with shifted field decoding would treat as reset-register writes or mode changes. It exercises the software reset both as a full word and as an early-aborted word after 12 ones: a design that lets the strobe cancel the reset would keep the old code. Finally, it measures the exact length of the ready low window after leaving power-down, and it clocks extra edges both outside a frame and after a completed frame.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic [1:0] {
    LOAD_NORMAL = 2'b00,
    LOAD_HIZ    = 2'b01,
    LOAD_R100K  = 2'b10,
    LOAD_R1K    = 2'b11
  } load_sel_e;

  // Leading bits of a frame that mark a software reset when all set.
  localparam int HDR_W = 8;

  function automatic logic header_is_reset(input logic [HDR_W-1:0] hdr);
    return &hdr;
  endfunction

  // Thermometer line index i is on when the segment value exceeds i.
  function automatic logic therm_line(input int unsigned idx, input int unsigned seg);
    return (idx < seg);
  endfunction

endpackage

// File: rtl/dacfe_sync_edge.sv
module dacfe_sync_edge #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      pipe[0] <= raw_i;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = ~prev_q & pipe[STAGES-1];
  assign fall_o = prev_q & ~pipe[STAGES-1];
endmodule

// File: rtl/dacfe_frame.sv
module dacfe_frame #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_fall_i,
  input  logic               sync_rise_i,
  input  logic               sclk_fall_i,
  input  logic               sdi_i,
  output logic               start_o,
  output logic               abort_o,
  output logic               commit_o,
  output logic               swreset_o,
  output logic [FRAME_W-1:0] word_o
);
  import dacfe_pkg::*;
  localparam int CW = $clog2(FRAME_W + 1);

  logic               active_q;
  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               lock_q;

  logic [FRAME_W-1:0] shifted;
  logic               last_edge;

  assign shifted   = {shreg_q[FRAME_W-2:0], sdi_i};
  assign last_edge = active_q && sclk_fall_i && (cnt_q == CW'(FRAME_W - 1));
  assign start_o   = sync_fall_i;
  assign abort_o   = active_q && sync_rise_i && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      shreg_q   <= '0;
      lock_q    <= 1'b0;
      commit_o  <= 1'b0;
      swreset_o <= 1'b0;
      word_o    <= '0;
    end else begin
      commit_o  <= 1'b0;
      swreset_o <= 1'b0;
      if (sync_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        shreg_q  <= '0;
        lock_q   <= 1'b0;
      end else if (sync_rise_i && active_q) begin
        if (lock_q) begin
          commit_o  <= 1'b1;
          swreset_o <= 1'b1;
          word_o    <= shreg_q;
        end
        active_q <= 1'b0;
        cnt_q    <= '0;
        shreg_q  <= '0;
        lock_q   <= 1'b0;
      end else if (active_q && sclk_fall_i) begin
        shreg_q <= shifted;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CW'(HDR_W - 1) && header_is_reset(shifted[HDR_W-1:0]))
          lock_q <= 1'b1;
        if (last_edge) begin
          commit_o  <= 1'b1;
          swreset_o <= lock_q;
          word_o    <= shifted;
          active_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs #(
  parameter int FRAME_W     = 24,
  parameter int CODE_W      = 16,
  parameter int MODE_W      = 2,
  parameter bit RESET_MID   = 1'b0,
  parameter int EXIT_CYCLES = 313
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic               swreset_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               ready_o,
  output logic               exit_start_o
);
  localparam logic [CODE_W-1:0] RST_CODE = RESET_MID ? (CODE_W'(1) << (CODE_W - 1)) : '0;
  localparam int TW      = $clog2(EXIT_CYCLES + 1);
  localparam int SEL_BIT = FRAME_W - 2;
  localparam int MODE_LO = FRAME_W - 2 - MODE_W;

  logic [CODE_W-1:0] code_q, code_nx, rcode_q, rcode_nx;
  logic [MODE_W-1:0] mode_q, mode_nx, field_mode;
  logic [TW-1:0]     timer_q;

  assign field_mode = word_i[MODE_LO +: MODE_W];

  always_comb begin
    code_nx  = code_q;
    rcode_nx = rcode_q;
    mode_nx  = mode_q;
    if (commit_i) begin
      if (swreset_i) begin
        code_nx = rcode_q;
        mode_nx = '0;
      end else begin
        mode_nx = field_mode;
        if (word_i[SEL_BIT])
          rcode_nx = word_i[CODE_W-1:0];
        else if (field_mode == '0)
          code_nx = word_i[CODE_W-1:0];
      end
    end
  end

  assign exit_start_o = (mode_q != '0) && (mode_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= RST_CODE;
      rcode_q <= RST_CODE;
      mode_q  <= '0;
      timer_q <= '0;
    end else begin
      code_q  <= code_nx;
      rcode_q <= rcode_nx;
      mode_q  <= mode_nx;
      if (exit_start_o)       timer_q <= TW'(EXIT_CYCLES);
      else if (timer_q != '0) timer_q <= timer_q - 1'b1;
    end
  end

  assign code_o  = code_q;
  assign mode_o  = mode_q;
  assign ready_o = (mode_q == '0) && (timer_q == '0);
endmodule

// File: rtl/dacfe_seg_decode.sv
module dacfe_seg_decode #(
  parameter int CODE_W   = 16,
  parameter int SEG_BITS = 4
) (
  input  logic [CODE_W-1:0]             code_i,
  output logic [(1<<SEG_BITS)-2:0]      therm_o,
  output logic [CODE_W-SEG_BITS-1:0]    bin_o
);
  import dacfe_pkg::*;
  localparam int TH_W  = (1 << SEG_BITS) - 1;
  localparam int BIN_W = CODE_W - SEG_BITS;

  logic [SEG_BITS-1:0] seg;
  assign seg = code_i[CODE_W-1 -: SEG_BITS];

  for (genvar i = 0; i < TH_W; i++) begin : g_th
    assign therm_o[i] = therm_line(i, int'(seg));
  end

  assign bin_o = code_i[BIN_W-1:0];
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int FRAME_W     = 24,
  parameter int CODE_W      = 16,
  parameter int SEG_BITS    = 4,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_MID   = 1'b0,
  parameter int EXIT_CYCLES = 313
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_n_i,
  input  logic                          sclk_i,
  input  logic                          sdi_i,
  output logic [CODE_W-1:0]             dac_code_o,
  output logic [MODE_W-1:0]             load_sel_o,
  output logic                          ready_o,
  output logic [(1<<SEG_BITS)-2:0]      seg_therm_o,
  output logic [CODE_W-SEG_BITS-1:0]    seg_bin_o
);
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  logic               frame_start, frame_abort, frame_commit, frame_swreset;
  logic [FRAME_W-1:0] frame_word;
  logic               exit_start;

  dacfe_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sdi_i, sclk_i, sync_n_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  dacfe_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_fall_i (pin_fall[0]),
    .sync_rise_i (pin_rise[0]),
    .sclk_fall_i (pin_fall[1]),
    .sdi_i       (pin_lvl[2]),
    .start_o     (frame_start),
    .abort_o     (frame_abort),
    .commit_o    (frame_commit),
    .swreset_o   (frame_swreset),
    .word_o      (frame_word)
  );

  dacfe_regs #(
    .FRAME_W(FRAME_W), .CODE_W(CODE_W), .MODE_W(MODE_W),
    .RESET_MID(RESET_MID), .EXIT_CYCLES(EXIT_CYCLES)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (frame_commit),
    .swreset_i    (frame_swreset),
    .word_i       (frame_word),
    .code_o       (dac_code_o),
    .mode_o       (load_sel_o),
    .ready_o      (ready_o),
    .exit_start_o (exit_start)
  );

  dacfe_seg_decode #(.CODE_W(CODE_W), .SEG_BITS(SEG_BITS)) u_seg (
    .code_i  (dac_code_o),
    .therm_o (seg_therm_o),
    .bin_o   (seg_bin_o)
  );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int CODE_W   = 16,
  parameter int SEG_BITS = 4,
  parameter int MODE_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_abort,
  input logic [CODE_W-1:0]        dac_code,
  input logic [MODE_W-1:0]        load_sel,
  input logic                     ready,
  input logic [(1<<SEG_BITS)-2:0] therm
);
  // R9
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm) == int'(dac_code[CODE_W-1 -: SEG_BITS]));

  // R9
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm + 1'b1) & therm) == '0);

  // R3
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> ($stable(dac_code) && $stable(load_sel)) ##1
                    ($stable(dac_code) && $stable(load_sel)));

  // R6
  pd_keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != '0 && $past(load_sel) == '0) |-> $stable(dac_code));

  // R10
  ready_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (load_sel == '0));

  // R10
  exit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel == '0 && $past(load_sel) != '0) |-> !ready);
endmodule

bind dac_serial_front dacfe_chk #(
  .CODE_W(CODE_W), .SEG_BITS(SEG_BITS), .MODE_W(MODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_abort (frame_abort),
  .dac_code    (dac_code_o),
  .load_sel    (load_sel_o),
  .ready       (ready_o),
  .therm       (seg_therm_o)
);

// File: tb/dac_serial_front_tb_top.sv
module dac_serial_front_tb_top;
  localparam int EXIT = 40;
  localparam int NV   = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [15:0] code;
  logic [1:0]  sel;
  logic        ready;
  logic [14:0] therm;
  logic [11:0] bin;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_serial_front #(.EXIT_CYCLES(EXIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code), .load_sel_o(sel), .ready_o(ready),
    .seg_therm_o(therm), .seg_bin_o(bin)
  );

  // {frame word, falling edges sent, expected code, expected load select}
  localparam logic [49:0] VEC [NV] = '{
    {24'h001234, 8'd24, 16'h1234, 2'd0},
    {24'h00ABCD, 8'd10, 16'h1234, 2'd0},
    {24'h105555, 8'd24, 16'h1234, 2'd1},
    {24'h200000, 8'd24, 16'h1234, 2'd2},
    {24'h30FFF0, 8'd24, 16'h1234, 2'd3},
    {24'h008001, 8'd24, 16'h8001, 2'd0},
    {24'h400777, 8'd24, 16'h8001, 2'd0},
    {24'h8F0042, 8'd24, 16'h0042, 2'd0},
    {24'hFFFFFF, 8'd24, 16'h0777, 2'd0},
    {24'h00F00F, 8'd24, 16'hF00F, 2'd0},
    {24'hFFFFFF, 8'd12, 16'h0777, 2'd0},
    {24'h000000, 8'd23, 16'h0777, 2'd0},
    {24'h100001, 8'd24, 16'h0777, 2'd1},
    {24'hFFFFFF, 8'd24, 16'h0777, 2'd0}
  };

  function automatic string vreq(input int idx);
    case (idx)
      0, 5, 9:    return "R2";
      1, 11:      return "R3";
      2, 3, 4, 12: return "R6";
      6, 7:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int edges);
    sync_n = 1'b0;
    wclk(4);
    for (int i = 0; i < edges; i++) begin
      sdi = w[23-i];
      wclk(4);
      sclk = 1'b0;
      wclk(4);
      sclk = 1'b1;
    end
    wclk(4);
    sync_n = 1'b1;
    wclk(12);
  endtask

  task automatic check_seg(input string tag);
    logic [14:0] et;
    for (int i = 0; i < 15; i++) et[i] = (i < int'(code[15:12]));
    check({tag, " R9 therm"}, {17'd0, therm}, {17'd0, et});
    check({tag, " R9 bin"}, {20'd0, bin}, {20'd0, code[11:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int lowcnt;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    @(negedge clk);
    // R1 reset state
    check("R1 code", {16'd0, code}, 32'h0);
    check("R1 sel", {30'd0, sel}, 32'd0);
    check("R1 ready", {31'd0, ready}, 32'd1);
    check_seg("R1");

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][49:26], int'(VEC[v][25:18]));
      wclk(EXIT + 20);
      @(negedge clk);
      check({vreq(v), " code"}, {16'd0, code}, {16'd0, VEC[v][17:2]});
      check("R5 sel", {30'd0, sel}, {30'd0, VEC[v][1:0]});
      check_seg(vreq(v));
    end

    // R4: clock edges with strobe high do nothing
    sdi = 1'b1;
    for (int i = 0; i < 24; i++) begin
      wclk(4); sclk = 1'b0; wclk(4); sclk = 1'b1;
    end
    wclk(12);
    @(negedge clk);
    check("R4 code", {16'd0, code}, 32'h0777);
    check("R4 sel", {30'd0, sel}, 32'd0);

    // R2: extra edges after the 24th while strobe stays low
    sync_n = 1'b0;
    wclk(4);
    for (int i = 0; i < 32; i++) begin
      sdi = (i < 24) ? logic'(24'h001111 >> (23 - i)) : 1'b1;
      wclk(4); sclk = 1'b0; wclk(4); sclk = 1'b1;
    end
    wclk(4);
    sync_n = 1'b1;
    wclk(12);
    @(negedge clk);
    check("R2 extra edges code", {16'd0, code}, 32'h1111);
    check("R2 extra edges sel", {30'd0, sel}, 32'd0);

    // R10: ready low in power-down, then exact exit window
    send(24'h300000, 24);
    wclk(EXIT + 10);
    @(negedge clk);
    check("R10 ready in pd", {31'd0, ready}, 32'd0);
    lowcnt = 0;
    fork
      send(24'h002222, 24);
      begin
        int guard = 0;
        @(negedge clk);
        while (sel != 2'd0 && guard < 2000) begin @(negedge clk); guard++; end
        while (!ready && guard < 4000) begin lowcnt++; @(negedge clk); guard++; end
      end
    join
    check("R10 exit window", lowcnt, EXIT);
    wclk(EXIT + 10);
    @(negedge clk);
    check("R10 ready after exit", {31'd0, ready}, 32'd1);
    check("R7 code after pd exit", {16'd0, code}, 32'h2222);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule